// File: doc/BRIEF.md
# Vectored Edge/Level Interrupt Controller

This block collects a vector of interrupt request inputs and turns them into a smaller set of parent interrupt lines. Each source can be set as edge sensitive or level sensitive. The block keeps, for every source, a pending bit, an in-service bit and a mask bit. A byte-wide vector entry per source picks which parent line that source drives. Input changes, mask writes and clear writes each start an evaluation. A raise evaluation serves the lowest-indexed source that is pending and unmasked. A lower evaluation retires the lowest-indexed source that is in service but no longer pending.

Software reaches the block through a small register port: valid, write enable, byte address and 32-bit write data, with read data returned on the following cycle. The 64-bit control registers are split into two 32-bit halves: the low half at the word base and the high half at base + 4. The vector and route tables are addressed one byte at a time. A polarity register is kept for software but does not affect capture. A small window of auto-control locations accepts accesses and discards them.

Top module: `vecroute_intc`

## Requirements
- R1: After reset the pending, in-service, edge-select, polarity, vector and route state is zero, every mask bit is 1 (masked) and every parent line is low.
- R2: An edge-select bit of 1 makes the source edge sensitive. Such a source becomes pending when its input is sampled high after having been sampled low. It stays pending when the input falls, until a clear write removes it.
- R3: An edge-select bit of 0 makes the source level sensitive. Its pending bit equals the input sampled at the last clock edge. A falling input starts a lower evaluation for that source.
- R4: A raise evaluation (a rising input, or bits being unmasked by a mask write) serves only the lowest-indexed candidate that is pending and unmasked. It sets that source's in-service bit and raises parent line number (vector byte modulo NPAR) one cycle later.
- R5: A lower evaluation (a falling input, bits becoming masked, or a clear write) picks the lowest-indexed candidate that is in service and not pending. It clears that source's in-service bit and drops its parent line one cycle later.
- R6: A mask write that unmasks bits (1 to 0) runs a raise evaluation over them. A mask write that masks bits (0 to 1) runs a lower evaluation over them, so a masked source that is still pending keeps its parent line high.
- R7: The clear register (word 0x10/0x14) is write-only and reads as 0. Writing a 1 affects only edge sources: their pending bit is cleared, a lower evaluation runs over them, and their in-service bits are cleared. Level sources are left untouched.
- R8: The status register (word 0x18/0x1C) reads as in-service AND NOT mask. A write to it loads the in-service bits directly.
- R9: The mask (0x00), edge-select (0x08) and polarity (0x20) registers are 64 bits wide. The low half is at the base and the high half at base + 4. Writing one half leaves the other half unchanged. Word offsets need address bits [1:0] = 0.
- R10: Vector entry i is at byte address 0x100 + i and route entry i is at 0x200 + i. Each entry is written from write data bits [7:0] and reads back zero-extended.
- R11: Addresses 0x28 to 0x2F are auto-control locations: writes to them are discarded and reads return 0. Polarity bits are stored and read back but never change capture.
- R12: A read returns its data on bus_rdata one cycle after the request cycle. In any cycle that follows a cycle with no read, bus_rdata is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NSRC | Interrupt request inputs, sampled every clock |
| bus_valid | input | 1 | Register access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| parent_irq | output | NPAR | Parent interrupt lines |

## Verification
The bench builds the block with its defaults: NSRC = 64 and NPAR = 8. Sixty-four sources place half of them behind the high register halves, so source 40 checks that writes to one half leave the other intact. Eight parent lines let a vector byte of 9 exercise the modulo mapping onto line 1. Edge sources 3 and 5 rising in the same cycle while masked, then unmasked together, show that only the lowest-indexed source is served.

// File: rtl/intc_pkg.sv
package intc_pkg;

  localparam int SRC_MAX = 64;

  typedef struct packed {
    logic       hit;
    logic [5:0] idx;
  } pick_t;

  // lowest set bit of a vector, scanned from the top so the last hit wins
  function automatic pick_t lowest_set(input logic [SRC_MAX-1:0] v);
    pick_t r;
    r.hit = 1'b0;
    r.idx = '0;
    for (int i = SRC_MAX - 1; i >= 0; i--) begin
      if (v[i]) begin
        r.hit = 1'b1;
        r.idx = 6'(i);
      end
    end
    return r;
  endfunction

  // replace one 32-bit half of a 64-bit value
  function automatic logic [63:0] merge_half(input logic [63:0] old,
                                             input logic [31:0] d,
                                             input logic        hi);
    return hi ? {d, old[31:0]} : {old[63:32], d};
  endfunction

  // select one 32-bit half of a 64-bit value
  function automatic logic [31:0] half_of(input logic [63:0] v, input logic hi);
    return hi ? v[63:32] : v[31:0];
  endfunction

  // place 32 bits into the chosen half, zero elsewhere
  function automatic logic [63:0] spread_half(input logic [31:0] d, input logic hi);
    return hi ? {d, 32'h0} : {32'h0, d};
  endfunction

endpackage

// File: rtl/intc_capture.sv
module intc_capture #(
  parameter int NSRC = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] irq_in,
  input  logic [NSRC-1:0] edge_sel,
  input  logic [NSRC-1:0] clr_pend,
  output logic [NSRC-1:0] pend_nx,
  output logic [NSRC-1:0] rise_ev,
  output logic [NSRC-1:0] fall_ev
);

  logic [NSRC-1:0] pend_q;
  logic [NSRC-1:0] prev_q;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    assign rise_ev[i] = irq_in[i] & ~prev_q[i];
    assign fall_ev[i] = ~irq_in[i] & prev_q[i];
    assign pend_nx[i] = edge_sel[i] ? ((pend_q[i] | rise_ev[i]) & ~clr_pend[i])
                                    : irq_in[i];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pend_q[i] <= 1'b0;
        prev_q[i] <= 1'b0;
      end else begin
        pend_q[i] <= pend_nx[i];
        prev_q[i] <= irq_in[i];
      end
    end

    // R2
    edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_sel[i] && pend_q[i] && !clr_pend[i]) |=> pend_q[i]);

    // R2
    edge_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_sel[i] && irq_in[i] && !prev_q[i] && !clr_pend[i]) |=> pend_q[i]);

    // R3
    level_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!edge_sel[i]) |=> (pend_q[i] == $past(irq_in[i])));
  end

endmodule

// File: rtl/intc_pick.sv
module intc_pick #(
  parameter int NSRC = 64,
  parameter int IW   = 6
) (
  input  logic [NSRC-1:0] cand,
  output logic            hit,
  output logic [IW-1:0]   idx,
  output logic [NSRC-1:0] onehot
);

  intc_pkg::pick_t p;

  assign p      = intc_pkg::lowest_set(intc_pkg::SRC_MAX'(cand));
  assign hit    = p.hit;
  assign idx    = p.idx[IW-1:0];
  assign onehot = p.hit ? (NSRC'(1) << p.idx) : '0;

endmodule

// File: rtl/intc_bytetab.sv
module intc_bytetab #(
  parameter int N  = 64,
  parameter int BW = 8,
  parameter int IW = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [IW-1:0]        widx,
  input  logic [BW-1:0]        wdata,
  output logic [N-1:0][BW-1:0] tab
);

  for (genvar e = 0; e < N; e++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n)
        tab[e] <= '0;
      else if (we && widx == IW'(e))
        tab[e] <= wdata;
    end
  end

endmodule

// File: rtl/vecroute_intc.sv
module vecroute_intc #(
  parameter int NSRC = 64,
  parameter int NPAR = 8,
  parameter int AW   = 12,
  parameter int BW   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] irq_in,
  input  logic            bus_valid,
  input  logic            bus_we,
  input  logic [AW-1:0]   bus_addr,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  output logic [NPAR-1:0] parent_irq
);

  localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1;
  localparam int PW = (NPAR > 1) ? $clog2(NPAR) : 1;
  localparam int NPICK = 4;
  localparam int PK_IN_RAISE  = 0;
  localparam int PK_MK_RAISE  = 1;
  localparam int PK_IN_LOWER  = 2;
  localparam int PK_REG_LOWER = 3;

  localparam logic [AW-1:0] A_MASK  = AW'(12'h000);
  localparam logic [AW-1:0] A_EDGE  = AW'(12'h008);
  localparam logic [AW-1:0] A_CLR   = AW'(12'h010);
  localparam logic [AW-1:0] A_STAT  = AW'(12'h018);
  localparam logic [AW-1:0] A_POL   = AW'(12'h020);
  localparam logic [AW-1:0] A_AUTO  = AW'(12'h028);
  localparam logic [AW-1:0] A_VEC   = AW'(12'h100);
  localparam logic [AW-1:0] A_ROUTE = AW'(12'h200);

  function automatic logic word_hit(input logic [AW-1:0] a, input logic [AW-1:0] base);
    return (a[AW-1:3] == base[AW-1:3]) && (a[1:0] == 2'b00);
  endfunction

  function automatic logic tab_hit(input logic [AW-1:0] a, input logic [AW-1:0] base);
    return (a >= base) && (a < base + AW'(NSRC));
  endfunction

  // ---------------- access decode ----------------
  logic rd_en, wr_en, hi_half;
  logic sel_mask, sel_edge, sel_clr, sel_stat, sel_pol, sel_auto, sel_vec, sel_route;
  logic wr_mask, wr_edge, wr_clr, wr_stat, wr_pol, wr_vec, wr_route;
  logic [IW-1:0] vec_idx, route_idx;

  assign rd_en     = bus_valid & ~bus_we;
  assign wr_en     = bus_valid & bus_we;
  assign hi_half   = bus_addr[2];
  assign sel_mask  = word_hit(bus_addr, A_MASK);
  assign sel_edge  = word_hit(bus_addr, A_EDGE);
  assign sel_clr   = word_hit(bus_addr, A_CLR);
  assign sel_stat  = word_hit(bus_addr, A_STAT);
  assign sel_pol   = word_hit(bus_addr, A_POL);
  assign sel_auto  = (bus_addr[AW-1:3] == A_AUTO[AW-1:3]);
  assign sel_vec   = tab_hit(bus_addr, A_VEC);
  assign sel_route = tab_hit(bus_addr, A_ROUTE);
  assign vec_idx   = IW'(bus_addr - A_VEC);
  assign route_idx = IW'(bus_addr - A_ROUTE);

  assign wr_mask  = wr_en & sel_mask;
  assign wr_edge  = wr_en & sel_edge;
  assign wr_clr   = wr_en & sel_clr;
  assign wr_stat  = wr_en & sel_stat;
  assign wr_pol   = wr_en & sel_pol;
  assign wr_vec   = wr_en & sel_vec;
  assign wr_route = wr_en & sel_route;

  // ---------------- state ----------------
  logic [NSRC-1:0] mask_q, edge_q, pol_q, isr_q;
  logic [NPAR-1:0] lines_q;
  logic [31:0]     rdata_q;
  logic [NSRC-1:0][BW-1:0] vec_tab, route_tab;

  logic [63:0] mask_w64, edge_w64, pol_w64, stat_w64, clr64, stat_view64;
  logic [NSRC-1:0] mask_nx, unmask_bits, newmask_bits, clr_edge;

  assign mask_w64     = intc_pkg::merge_half(64'(mask_q), bus_wdata, hi_half);
  assign edge_w64     = intc_pkg::merge_half(64'(edge_q), bus_wdata, hi_half);
  assign pol_w64      = intc_pkg::merge_half(64'(pol_q),  bus_wdata, hi_half);
  assign stat_w64     = intc_pkg::merge_half(64'(isr_q),  bus_wdata, hi_half);
  assign clr64        = intc_pkg::spread_half(bus_wdata, hi_half);
  assign stat_view64  = 64'(isr_q & ~mask_q);

  assign mask_nx      = wr_mask ? mask_w64[NSRC-1:0] : mask_q;
  assign unmask_bits  = mask_q & ~mask_nx;
  assign newmask_bits = ~mask_q & mask_nx;
  assign clr_edge     = wr_clr ? (clr64[NSRC-1:0] & edge_q) : '0;

  // ---------------- capture ----------------
  logic [NSRC-1:0] pend_nx, rise_ev, fall_ev;

  intc_capture #(.NSRC(NSRC)) u_capture (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_in   (irq_in),
    .edge_sel (edge_q),
    .clr_pend (clr_edge),
    .pend_nx  (pend_nx),
    .rise_ev  (rise_ev),
    .fall_ev  (fall_ev)
  );

  // ---------------- evaluations ----------------
  logic [NSRC-1:0] pick_cand   [NPICK];
  logic [NSRC-1:0] pick_oh     [NPICK];
  logic [IW-1:0]   pick_idx    [NPICK];
  logic [PW-1:0]   line_sel    [NPICK];
  logic [NPAR-1:0] line_oh     [NPICK];
  logic [NPICK-1:0] pick_hit;

  assign pick_cand[PK_IN_RAISE]  = rise_ev & pend_nx & ~mask_nx;
  assign pick_cand[PK_MK_RAISE]  = unmask_bits & pend_nx & ~mask_nx;
  assign pick_cand[PK_IN_LOWER]  = fall_ev & isr_q & ~pend_nx;
  assign pick_cand[PK_REG_LOWER] = (newmask_bits | clr_edge) & isr_q & ~pend_nx;

  for (genvar k = 0; k < NPICK; k++) begin : g_pick
    intc_pick #(.NSRC(NSRC), .IW(IW)) u_pick (
      .cand   (pick_cand[k]),
      .hit    (pick_hit[k]),
      .idx    (pick_idx[k]),
      .onehot (pick_oh[k])
    );
    assign line_sel[k] = vec_tab[pick_idx[k]][PW-1:0];
    assign line_oh[k]  = pick_hit[k] ? (NPAR'(1) << line_sel[k]) : '0;
  end

  logic [NSRC-1:0] isr_set, isr_clr;
  logic [NPAR-1:0] lines_set, lines_clr;

  assign isr_set   = pick_oh[PK_IN_RAISE] | pick_oh[PK_MK_RAISE];
  assign isr_clr   = pick_oh[PK_IN_LOWER] | pick_oh[PK_REG_LOWER] | clr_edge;
  assign lines_set = line_oh[PK_IN_RAISE] | line_oh[PK_MK_RAISE];
  assign lines_clr = line_oh[PK_IN_LOWER] | line_oh[PK_REG_LOWER];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q  <= '1;
      edge_q  <= '0;
      pol_q   <= '0;
      isr_q   <= '0;
      lines_q <= '0;
    end else begin
      mask_q <= mask_nx;
      if (wr_edge) edge_q <= edge_w64[NSRC-1:0];
      if (wr_pol)  pol_q  <= pol_w64[NSRC-1:0];
      isr_q   <= wr_stat ? stat_w64[NSRC-1:0] : ((isr_q & ~isr_clr) | isr_set);
      lines_q <= (lines_q & ~lines_clr) | lines_set;
    end
  end

  // ---------------- tables ----------------
  intc_bytetab #(.N(NSRC), .BW(BW), .IW(IW)) u_vec_tab (
    .clk (clk), .rst_n (rst_n), .we (wr_vec), .widx (vec_idx),
    .wdata (bus_wdata[BW-1:0]), .tab (vec_tab)
  );

  intc_bytetab #(.N(NSRC), .BW(BW), .IW(IW)) u_route_tab (
    .clk (clk), .rst_n (rst_n), .we (wr_route), .widx (route_idx),
    .wdata (bus_wdata[BW-1:0]), .tab (route_tab)
  );

  // ---------------- read path ----------------
  logic [31:0] rd_val;

  always_comb begin
    rd_val = '0;
    if (sel_mask)       rd_val = intc_pkg::half_of(64'(mask_q), hi_half);
    else if (sel_edge)  rd_val = intc_pkg::half_of(64'(edge_q), hi_half);
    else if (sel_stat)  rd_val = intc_pkg::half_of(stat_view64, hi_half);
    else if (sel_pol)   rd_val = intc_pkg::half_of(64'(pol_q), hi_half);
    else if (sel_vec)   rd_val = 32'(vec_tab[vec_idx]);
    else if (sel_route) rd_val = 32'(route_tab[route_idx]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rd_en ? rd_val : '0;
  end

  assign bus_rdata  = rdata_q;
  assign parent_irq = lines_q;

  // ---------------- assertions ----------------
  // R4
  raise_serve_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pick_hit[PK_IN_RAISE] && !wr_stat) |=>
      (isr_q[$past(pick_idx[PK_IN_RAISE])] && parent_irq[$past(line_sel[PK_IN_RAISE])]));

  // R5
  lower_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pick_hit[PK_IN_LOWER] && !wr_stat) |=> !isr_q[$past(pick_idx[PK_IN_LOWER])]);

  // R7
  clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> ((isr_q & $past(clr_edge)) == '0));

  // R8
  status_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && sel_stat) |=> (bus_rdata == intc_pkg::half_of($past(stat_view64), $past(hi_half))));

  // R11
  auto_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && sel_auto) |=> (bus_rdata == 32'h0));

  // R12
  idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> (bus_rdata == 32'h0));

endmodule

// File: tb/vecroute_intc_test.sv
module vecroute_intc_test;

  localparam int NSRC = 64;
  localparam int NPAR = 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NSRC-1:0] irq_in = '0;
  logic            bus_valid = 1'b0;
  logic            bus_we = 1'b0;
  logic [11:0]     bus_addr = '0;
  logic [31:0]     bus_wdata = '0;
  logic [31:0]     bus_rdata;
  logic [NPAR-1:0] parent_irq;

  vecroute_intc #(.NSRC(NSRC), .NPAR(NPAR)) uut (
    .clk (clk), .rst_n (rst_n), .irq_in (irq_in),
    .bus_valid (bus_valid), .bus_we (bus_we), .bus_addr (bus_addr),
    .bus_wdata (bus_wdata), .bus_rdata (bus_rdata), .parent_irq (parent_irq)
  );

  always #5 clk = ~clk;

  typedef struct {
    string       req;
    int          kind;   // 0 = parent lines, 1 = read data
    logic [63:0] exp;
    int          due;
  } sb_item_t;

  sb_item_t sb[$];
  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compares every item whose cycle has come
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      sb_item_t it;
      logic [63:0] act;
      it  = sb.pop_front();
      act = (it.kind == 0) ? 64'(parent_irq) : 64'(bus_rdata);
      n_chk++;
      if (act !== it.exp || it.due != cyc) begin
        n_fail++;
        $display("FAIL %s: got %h expected %h", it.req, act, it.exp);
      end
    end
  end

  function automatic void push(input string r, input int k, input logic [63:0] e);
    sb.push_back('{r, k, e, cyc + 1});
  endfunction

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_valid = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string r);
    bus_valid = 1'b1; bus_we = 1'b0; bus_addr = a;
    push(r, 1, 64'(e));
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic expect_lines(input logic [NPAR-1:0] e, input string r);
    push(r, 0, 64'(e));
    @(negedge clk);
  endtask

  task automatic set_in(input int i, input logic v);
    irq_in[i] = v;
    @(negedge clk);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    expect_lines(8'h00, "R1 lines low");
    rd(12'h000, 32'hffffffff, "R1 mask low half");
    rd(12'h004, 32'hffffffff, "R1 mask high half");
    rd(12'h018, 32'h0, "R1 status");
    rd(12'h008, 32'h0, "R1 edge select");
    rd(12'h103, 32'h0, "R1 vector entry");

    // configuration
    wr(12'h103, 32'h2);
    wr(12'h105, 32'h2);
    wr(12'h107, 32'h9);
    wr(12'h128, 32'h5);
    wr(12'h008, 32'h28);      // sources 3 and 5 edge
    wr(12'h000, 32'h0);       // unmask low half
    expect_lines(8'h00, "R6 unmask with nothing pending");
    push("R12 idle read data", 1, 64'h0);
    @(negedge clk);

    // edge source
    set_in(3, 1'b1);
    expect_lines(8'h04, "R2 edge rise raises line 2");
    rd(12'h018, 32'h8, "R8 status shows source 3");
    set_in(3, 1'b0);
    expect_lines(8'h04, "R2 edge fall keeps line");
    rd(12'h018, 32'h8, "R2 still in service after fall");
    wr(12'h010, 32'h8);
    expect_lines(8'h00, "R7 clear drops line");
    rd(12'h018, 32'h0, "R7 status after clear");
    rd(12'h010, 32'h0, "R7 clear reads zero");

    // level source, vector 9 maps to line 1
    set_in(7, 1'b1);
    expect_lines(8'h02, "R4 vector modulo NPAR");
    rd(12'h018, 32'h80, "R3 level pending in service");
    wr(12'h010, 32'h80);
    expect_lines(8'h02, "R7 clear ignores level source");
    rd(12'h018, 32'h80, "R7 level in service kept");
    wr(12'h000, 32'h80);      // mask source 7 while still pending
    expect_lines(8'h02, "R6 masked pending keeps line");
    rd(12'h018, 32'h0, "R8 status hides masked");
    set_in(7, 1'b0);
    expect_lines(8'h00, "R5 falling level input lowers");
    rd(12'h018, 32'h0, "R3 level retired");

    // two edges while masked, then one unmask evaluation
    wr(12'h000, 32'hffffffff);
    irq_in[3] = 1'b1;
    irq_in[5] = 1'b1;
    @(negedge clk);
    expect_lines(8'h00, "R6 masked edges stay quiet");
    wr(12'h000, 32'h0);
    expect_lines(8'h04, "R4 unmask serves lowest");
    rd(12'h018, 32'h8, "R4 only one source served");
    wr(12'h010, 32'h8);
    expect_lines(8'h00, "R5 clear lowers source 3");
    rd(12'h018, 32'h0, "R5 source 5 not in service");
    wr(12'h010, 32'h20);
    irq_in[3] = 1'b0;
    irq_in[5] = 1'b0;
    @(negedge clk);

    // high half, polarity has no effect
    wr(12'h020, 32'hffff);
    wr(12'h004, 32'hfffffeff);
    rd(12'h004, 32'hfffffeff, "R9 mask high half written");
    rd(12'h000, 32'h0, "R9 mask low half unchanged");
    set_in(40, 1'b1);
    expect_lines(8'h20, "R11 polarity ignored, line 5");
    rd(12'h01c, 32'h100, "R8 status high half");
    rd(12'h020, 32'hffff, "R11 polarity read back");
    set_in(40, 1'b0);
    expect_lines(8'h00, "R3 source 40 lowered");
    wr(12'h00c, 32'h1);
    rd(12'h008, 32'h28, "R9 edge low half unchanged");
    rd(12'h00c, 32'h1, "R9 edge high half");

    // auto-control window
    wr(12'h028, 32'hdeadbeef);
    rd(12'h028, 32'h0, "R11 auto-control reads zero");
    rd(12'h02c, 32'h0, "R11 auto-control high reads zero");

    // status load
    wr(12'h018, 32'h10);
    rd(12'h018, 32'h10, "R8 status write loads");
    expect_lines(8'h00, "R8 status load leaves lines");

    // byte tables
    wr(12'h20a, 32'hffffffa5);
    rd(12'h20a, 32'ha5, "R10 route entry byte");
    rd(12'h107, 32'h9, "R10 vector entry byte");

    repeat (3) @(negedge clk);
    done = 1;
    summary();
    $finish;
  end

endmodule